// File: doc/BRIEF.md
# Descriptor-Driven Block Copy Channel

This block is one DMA channel that keeps its working set in memory instead of local registers. Three 32-bit words at a fixed descriptor base hold the transfer parameters. They are, in order, the source address, the destination address and a control word. On each transfer request the channel asks the CPU for the bus. Once granted, it reads the descriptor, copies up to one block of items from source to destination, and writes back the advanced addresses and remaining count. It then hands the bus back.

Software sets up a descriptor, sets the channel enable, and lets a peripheral pulse the request line. Each request moves at most one block. When the remaining count runs out, the channel raises a sticky done flag and, if enabled, an interrupt. The memory port is a plain word master with a one-cycle read latency. A read issued in one cycle returns data on `mem_rdata` in the next.

Control word layout: bits [15:0] hold the remaining count, bits [23:16] the block size, bits [25:24] the source mode and bits [27:26] the destination mode. A mode code of 00 holds the address, 01 adds 1, 10 subtracts 1, and 11 behaves as 00.

Top module: `dma_desc_engine`

## Requirements
- R1: While `ch_enable` is 0, requests are ignored. `bus_req` stays 0, no memory access takes place, and a request seen while disabled is not remembered once the channel is enabled.
- R2: A request raises `bus_req`. No memory read or write is issued before `bus_gnt` is 1.
- R3: After the grant, the first three reads go to base+0, base+4 and base+8, in that order.
- R4: One request moves n = min(block size, remaining count) items, with a block size of 0 treated as 1. Each item is read at the current source address and written to the current destination address.
- R5: After each item, each address is updated by its 2-bit mode from the control word (bits [25:24] source, [27:26] destination). 00 and 11 hold it, 01 adds 1 and 10 subtracts 1.
- R6: `xfer_ack` is high for exactly one cycle per item moved. `xfer_end` is high in exactly one such cycle, the one in which the count goes from 1 to 0.
- R7: After the items, the source word is written back only if its mode is 01 or 10, and the destination word likewise. The control word is always written back with the block size and modes unchanged and the new count in bits [15:0].
- R8: From the grant cycle to the last write-back, the bus is held for 6+4n cycles when neither address moves, 7+4n when one moves, and 8+4n when both move.
- R9: `done` is set when a block ends with a count of 0 and stays set until `done_clr` is pulsed. `irq` equals `done` AND `irq_enable`.
- R10: A request arriving while a block is in progress is served right after the bus is released, unless that block ended with a count of 0. In that case the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | 1 | Channel enable |
| irq_enable | input | 1 | Interrupt enable |
| done_clr | input | 1 | Pulse to clear the done flag |
| xfer_req | input | 1 | Transfer request |
| bus_req | output | 1 | Bus ownership request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| mem_addr | output | AW | Byte address of the access |
| mem_re | output | 1 | Read strobe, data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_re` |
| xfer_ack | output | 1 | High during each item write |
| xfer_end | output | 1 | High during the item write that empties the count |
| done | output | 1 | Sticky count-exhausted flag |
| irq | output | 1 | Interrupt output |

## Verification
The assertions take two things for granted. Once `bus_gnt` has been given, it stays high for as long as `bus_req` is high. Read data follows its strobe by exactly one cycle. The bench models grant as `bus_req` gated by an allow flag that only goes from 0 to 1 while a request waits, and its memory model answers every read one cycle later. Descriptor fields are drawn at random with source and destination windows kept apart and away from the descriptor words. That way no item can overwrite a descriptor or a pending source value, and the expected memory image stays exact.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_F0,
    ST_F1,
    ST_F2,
    ST_F3,
    ST_RD,
    ST_CAP,
    ST_WR,
    ST_STEP,
    ST_WB_SRC,
    ST_WB_DST,
    ST_WB_CTL
  } dma_state_e;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_INC  = 2'b01,
    AM_DEC  = 2'b10,
    AM_RSVD = 2'b11
  } addr_mode_e;

  function automatic logic mode_moves(input logic [1:0] m);
    return (m == AM_INC) || (m == AM_DEC);
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] addr_o
);
  import dma_desc_pkg::*;

  always_comb begin
    unique case (mode_i)
      AM_INC:  addr_o = addr_i + AW'(1);
      AM_DEC:  addr_o = addr_i - AW'(1);
      default: addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic req_i,
  input  logic consume_i,
  input  logic drop_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst || !enable_i) pend_q <= 1'b0;
    else if (consume_i)   pend_q <= req_i;
    else if (drop_i)      pend_q <= 1'b0;
    else                  pend_q <= pend_q | req_i;
  end

  assign pend_o = pend_q;

  // R1
  pend_cleared_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> !pend_o);
endmodule

// File: rtl/dma_done_flag.sv
module dma_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic done_o,
  output logic irq_o
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst)        done_q <= 1'b0;
    else if (set_i) done_q <= 1'b1;
    else if (clr_i) done_q <= 1'b0;
  end

  assign done_o = done_q;
  assign irq_o  = done_q & irq_en_i;

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clr_i) |=> done_o);
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CNT_W     = 16,
  parameter int          BLK_W     = 8,
  parameter logic [31:0] DESC_BASE = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ch_enable,
  input  logic          irq_enable,
  input  logic          done_clr,
  input  logic          xfer_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_ack,
  output logic          xfer_end,
  output logic          done,
  output logic          irq
);
  import dma_desc_pkg::*;

  localparam int BLK_LSB = CNT_W;
  localparam int SM_LSB  = CNT_W + BLK_W;
  localparam int DM_LSB  = SM_LSB + 2;
  localparam logic [AW-1:0] A_SRC = AW'(DESC_BASE);
  localparam logic [AW-1:0] A_DST = AW'(DESC_BASE) + AW'(4);
  localparam logic [AW-1:0] A_CTL = AW'(DESC_BASE) + AW'(8);

  dma_state_e       state_q;
  logic [AW-1:0]    src_q, dst_q, src_nx, dst_nx;
  logic [DW-1:0]    ctl_q, data_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BLK_W-1:0] items_q, blk_eff;
  logic [BLK_W:0]   items_inc;
  logic [1:0]       smode, dmode;
  logic             pend;

  assign smode     = ctl_q[SM_LSB +: 2];
  assign dmode     = ctl_q[DM_LSB +: 2];
  assign blk_eff   = (ctl_q[BLK_LSB +: BLK_W] == '0) ? BLK_W'(1) : ctl_q[BLK_LSB +: BLK_W];
  assign items_inc = {1'b0, items_q} + 1'b1;

  function automatic dma_state_e wb_first(input logic [1:0] sm, input logic [1:0] dm);
    if (mode_moves(sm))      return ST_WB_SRC;
    else if (mode_moves(dm)) return ST_WB_DST;
    else                     return ST_WB_CTL;
  endfunction

  dma_addr_step #(.AW(AW)) i_src_step (.addr_i(src_q), .mode_i(smode), .addr_o(src_nx));
  dma_addr_step #(.AW(AW)) i_dst_step (.addr_i(dst_q), .mode_i(dmode), .addr_o(dst_nx));

  dma_req_latch i_req (
    .clk(clk), .rst(rst), .enable_i(ch_enable), .req_i(xfer_req),
    .consume_i(state_q == ST_F0),
    .drop_i((state_q == ST_WB_CTL) && (cnt_q == '0)),
    .pend_o(pend)
  );

  dma_done_flag i_done (
    .clk(clk), .rst(rst),
    .set_i((state_q == ST_WB_CTL) && (cnt_q == '0)),
    .clr_i(done_clr), .irq_en_i(irq_enable),
    .done_o(done), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      ctl_q   <= '0;
      cnt_q   <= '0;
      items_q <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ch_enable && pend) state_q <= ST_REQ;
        ST_REQ:  if (bus_gnt) state_q <= ST_F0;
        ST_F0:   state_q <= ST_F1;
        ST_F1: begin
          src_q   <= AW'(mem_rdata);
          state_q <= ST_F2;
        end
        ST_F2: begin
          dst_q   <= AW'(mem_rdata);
          state_q <= ST_F3;
        end
        ST_F3: begin
          ctl_q   <= mem_rdata;
          cnt_q   <= mem_rdata[CNT_W-1:0];
          items_q <= '0;
          state_q <= (mem_rdata[CNT_W-1:0] != '0) ? ST_RD
                     : wb_first(mem_rdata[SM_LSB +: 2], mem_rdata[DM_LSB +: 2]);
        end
        ST_RD:  state_q <= ST_CAP;
        ST_CAP: begin
          data_q  <= mem_rdata;
          state_q <= ST_WR;
        end
        ST_WR:  state_q <= ST_STEP;
        ST_STEP: begin
          src_q   <= src_nx;
          dst_q   <= dst_nx;
          cnt_q   <= cnt_q - CNT_W'(1);
          items_q <= items_inc[BLK_W-1:0];
          if ((cnt_q == CNT_W'(1)) || (items_inc == {1'b0, blk_eff}))
            state_q <= wb_first(smode, dmode);
          else
            state_q <= ST_RD;
        end
        ST_WB_SRC: state_q <= mode_moves(dmode) ? ST_WB_DST : ST_WB_CTL;
        ST_WB_DST: state_q <= ST_WB_CTL;
        ST_WB_CTL: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req  = (state_q != ST_IDLE);
  assign mem_re   = (state_q == ST_F0) || (state_q == ST_F1) ||
                    (state_q == ST_F2) || (state_q == ST_RD);
  assign mem_we   = (state_q == ST_WR) || (state_q == ST_WB_SRC) ||
                    (state_q == ST_WB_DST) || (state_q == ST_WB_CTL);
  assign xfer_ack = (state_q == ST_WR);
  assign xfer_end = (state_q == ST_WR) && (cnt_q == CNT_W'(1));

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_F0, ST_WB_SRC: mem_addr = A_SRC;
      ST_F1, ST_WB_DST: mem_addr = A_DST;
      ST_F2, ST_WB_CTL: mem_addr = A_CTL;
      ST_RD:            mem_addr = src_q;
      ST_WR:            mem_addr = dst_q;
      default:          mem_addr = '0;
    endcase
    unique case (state_q)
      ST_WR:     mem_wdata = data_q;
      ST_WB_SRC: mem_wdata = DW'(src_q);
      ST_WB_DST: mem_wdata = DW'(dst_q);
      ST_WB_CTL: mem_wdata = {ctl_q[DW-1:CNT_W], cnt_q};
      default:   mem_wdata = '0;
    endcase
  end

  // R1
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(ch_enable));
  // R2
  access_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> bus_gnt);
  // R4
  item_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STEP) |-> ((items_q < blk_eff) && (cnt_q != '0)));
  // R9
  done_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(bus_req));
endmodule

// File: tb/test_dma_desc_engine.sv
`timescale 1ns/1ps
module test_dma_desc_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ch_enable = 1'b0, irq_enable = 1'b0, done_clr = 1'b0, xfer_req = 1'b0;
  logic        bus_req, bus_gnt, mem_re, mem_we, xfer_ack, xfer_end, done, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        gnt_allow = 1'b1;

  always #4 clk = ~clk;

  assign bus_gnt = bus_req & gnt_allow;

  dma_desc_engine i_dma_desc_engine (
    .clk(clk), .rst(rst), .ch_enable(ch_enable), .irq_enable(irq_enable),
    .done_clr(done_clr), .xfer_req(xfer_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .xfer_ack(xfer_ack), .xfer_end(xfer_end),
    .done(done), .irq(irq)
  );

  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  logic [31:0] rd_log [3];
  int rd_n, ack_n, end_n, wsrc_n, wdst_n, tenure, req_seen;
  int exp_n, exp_tenure, exp_end, exp_wsrc, exp_wdst;
  bit exp_done;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re && rd_n < 3) begin rd_log[rd_n] <= mem_addr; rd_n <= rd_n + 1; end
    if (mem_re || mem_we) if (rd_n >= 3 || !mem_re) ; // no extra bookkeeping
    ack_n <= ack_n + int'(xfer_ack);
    end_n <= end_n + int'(xfer_end);
    if (mem_we && mem_addr == 32'd0) wsrc_n <= wsrc_n + 1;
    if (mem_we && mem_addr == 32'd4) wdst_n <= wdst_n + 1;
    if (bus_req && bus_gnt) tenure <= tenure + 1;
    if (bus_req) req_seen <= 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'b01) return a + 32'd1;
    if (m == 2'b10) return a - 32'd1;
    return a;
  endfunction

  // reference model: one request applied to exp_mem
  task automatic model();
    logic [31:0] s, d, c;
    int cnt, be, n;
    logic [1:0] sm, dm;
    s = exp_mem[0]; d = exp_mem[4]; c = exp_mem[8];
    cnt = int'(c[15:0]); be = (c[23:16] == 8'd0) ? 1 : int'(c[23:16]);
    sm = c[25:24]; dm = c[27:26];
    n = (cnt < be) ? cnt : be;
    for (int i = 0; i < n; i++) begin
      exp_mem[d[7:0]] = exp_mem[s[7:0]];
      s = step(s, sm); d = step(d, dm);
    end
    cnt -= n;
    exp_n = n;
    exp_end = (n > 0 && cnt == 0) ? 1 : 0;
    exp_wsrc = (sm == 2'b01 || sm == 2'b10) ? 1 : 0;
    exp_wdst = (dm == 2'b01 || dm == 2'b10) ? 1 : 0;
    exp_tenure = 6 + 4 * n + exp_wsrc + exp_wdst;
    if (exp_wsrc == 1) exp_mem[0] = s;
    if (exp_wdst == 1) exp_mem[4] = d;
    exp_mem[8] = {c[31:16], 16'(cnt)};
    if (cnt == 0) exp_done = 1'b1;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [1:0] sm,
                       input logic [1:0] dm, input logic [7:0] blk, input logic [15:0] cnt);
    @(negedge clk);
    mem[0] = s; mem[4] = d; mem[8] = {4'h0, dm, sm, blk, cnt};
    exp_mem[0] = mem[0]; exp_mem[4] = mem[4]; exp_mem[8] = mem[8];
    rd_n = 0; ack_n = 0; end_n = 0; wsrc_n = 0; wdst_n = 0; tenure = 0; req_seen = 0;
    model();
  endtask

  task automatic pulse_req();
    @(negedge clk) xfer_req = 1'b1;
    @(negedge clk) xfer_req = 1'b0;
  endtask

  task automatic wait_release();
    while (bus_req !== 1'b1) @(negedge clk);
    while (bus_req !== 1'b0) @(negedge clk);
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, (first < 0) ? 32'd0 : mem[first], (first < 0) ? 32'd0 : exp_mem[first]);
  endtask

  task automatic check_block();
    check(rd_log[0] == 32'd0 && rd_log[1] == 32'd4 && rd_log[2] == 32'd8, "R3 descriptor read order",
          {rd_log[0][7:0], rd_log[1][7:0], rd_log[2][7:0]}, 32'h000408);
    check(ack_n == exp_n, "R4/R6 ack cycles", ack_n, exp_n);
    check(end_n == exp_end, "R6 end pulses", end_n, exp_end);
    check(wsrc_n == exp_wsrc && wdst_n == exp_wdst, "R7 address write-backs",
          {wsrc_n[15:0], wdst_n[15:0]}, {exp_wsrc[15:0], exp_wdst[15:0]});
    check(tenure == exp_tenure, "R8 bus tenure", tenure, exp_tenure);
    check_mem("R4/R5/R7 memory image");
    check(done == exp_done, "R9 done flag", done, exp_done);
    check(irq == (exp_done & irq_enable), "R9 irq", irq, exp_done & irq_enable);
  endtask

  task automatic clear_done();
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
    exp_done = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    for (int i = 0; i < 256; i++) begin mem[i] = $urandom; exp_mem[i] = mem[i]; end
    mem_rdata = '0;
    rd_n = 0; ack_n = 0; end_n = 0; wsrc_n = 0; wdst_n = 0; tenure = 0; req_seen = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_req == 0 && done == 0 && irq == 0 && mem_re == 0 && mem_we == 0,
          "reset state", {bus_req, done, irq, mem_re, mem_we}, 0);

    // R1: request while disabled ignored, not remembered
    setup(32'd40, 32'd150, 2'b01, 2'b01, 8'd2, 16'd3);
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    exp_done = 1'b0;
    pulse_req();
    repeat (8) @(negedge clk);
    ch_enable = 1'b1;
    repeat (8) @(negedge clk);
    check(req_seen == 0, "R1 disabled request ignored", req_seen, 0);
    check_mem("R1 memory untouched");

    // R2: no access before grant
    setup(32'd40, 32'd150, 2'b01, 2'b01, 8'd2, 16'd3);
    gnt_allow = 1'b0;
    pulse_req();
    repeat (5) @(negedge clk);
    check(bus_req == 1'b1, "R2 bus request raised", bus_req, 1);
    check(rd_n == 0, "R2 no read before grant", rd_n, 0);
    gnt_allow = 1'b1;
    wait_release();
    check_block();

    // directed: block size 0, both fixed, reserved mode
    setup(32'd60, 32'd170, 2'b00, 2'b11, 8'd0, 16'd5);
    pulse_req(); wait_release(); check_block();
    // directed: count 0 on entry, decrement modes
    setup(32'd60, 32'd170, 2'b10, 2'b10, 8'd4, 16'd0);
    pulse_req(); wait_release(); check_block();
    clear_done();
    check(done == 0 && irq == 0, "R9 done cleared", done, 0);
    // directed: count reaches 0 with interrupts on
    irq_enable = 1'b1;
    setup(32'd70, 32'd180, 2'b01, 2'b10, 8'd4, 16'd3);
    pulse_req(); wait_release(); check_block();
    clear_done();

    // R10: request during block served after release
    setup(32'd50, 32'd160, 2'b01, 2'b01, 8'd2, 16'd10);
    pulse_req();
    repeat (4) @(negedge clk);
    pulse_req();
    while (bus_req !== 1'b0) @(negedge clk);
    begin
      int seen = 0;
      for (int i = 0; i < 3; i++) begin @(negedge clk); if (bus_req) seen = 1; end
      check(seen == 1, "R10 latched request served", seen, 1);
    end
    model();
    wait_release();
    check_mem("R10 second block memory image");
    // R10: latched request dropped when count exhausted
    setup(32'd50, 32'd160, 2'b01, 2'b01, 8'd4, 16'd2);
    pulse_req();
    repeat (4) @(negedge clk);
    pulse_req();
    while (bus_req !== 1'b0) @(negedge clk);
    req_seen = 0;
    repeat (6) @(negedge clk);
    check(req_seen == 0, "R10 request dropped after count 0", req_seen, 0);
    check_mem("R10 memory after drop");
    clear_done();

    // random blocks
    for (int k = 0; k < 40; k++) begin
      irq_enable = $urandom_range(0, 1);
      setup(32'($urandom_range(40, 100)), 32'($urandom_range(150, 210)),
            2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            8'($urandom_range(0, 5)), 16'($urandom_range(0, 7)));
      pulse_req(); wait_release(); check_block();
      if ($urandom_range(0, 2) == 0) clear_done();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule